// File: doc/BRIEF.md
# LCD Row Driver Scan Logic

This block is the digital core of a dot-matrix LCD row (common) driver. A shift register with one stage per row carries a select token from row to row. The token advances on each falling edge of a slow scan clock, which the block samples in its own system clock domain. A direction input picks the shift order. The same input also decides which of the two cascade pins receives data and which one sends it on. Several blocks can therefore be chained into a taller scan, with the panel fed from either end.

For every row the block produces a 2-bit drive-level code. The analog output stage turns this code into one of four bias voltages. The code depends on three things: the row's token bit, the frame AC polarity input and an active-low blanking input. Blanking has two build-time variants. In one, every row is forced to the topmost level. In the other, every row is forced to the non-select level for the current polarity. In both variants, blanking empties the shift register.

Top module: `lcdrow_scan`

## Requirements
- R1: After reset the register holds no token. With `ac` low, every row code is 2'b10.
- R2: With `dir_rev` low, `cas1_oe` is 0 and `cas2_oe` is 1. Each detected falling edge of `scan_clk` moves row k's bit to row k+1, and row 0 takes `cas1_in`. Row codes show the new state no more than 3 `clk` rising edges after `scan_clk` falls.
- R3: With `dir_rev` high, `cas1_oe` is 1 and `cas2_oe` is 0. Each falling edge moves row k's bit to row k-1, and row ROWS-1 takes `cas2_in`.
- R4: The output-enabled cascade pin carries the last stage in shift order: row ROWS-1 when `dir_rev` is low, row 0 when it is high. The other output pin stays 0. A token that enters one end therefore appears on the output pin after ROWS falling edges.
- R5: Row r's code sits at `row_lvl[2r+1:2r]`. The codes are 00 = V0 (top), 01 = V1, 10 = V4 and 11 = V5 (bottom). With blanking inactive, a selected row gives 11 when `ac` is high and 00 when it is low. A non-selected row gives 01 when `ac` is high and 10 when it is low.
- R6: In the force-top variant (`BLANK_MODE` = BLANK_FORCE_TOP), a low `blank_n` sets every row code to 00 combinationally, whatever `ac` and the register hold.
- R7: In the force-unselect variant (`BLANK_MODE` = BLANK_FORCE_UNSEL), a low `blank_n` sets every row code combinationally to 01 when `ac` is high and to 10 when it is low.
- R8: A low `blank_n` clears the register from the next `clk` edge onward. Any scan falling edge detected while it is low, including one that falls together with `blank_n`, is ignored. Shifting resumes with the first falling edge after release.
- R9: Without a detected falling edge, the register holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_clk | input | 1 | Scan clock; shifting happens on its falling edge |
| dir_rev | input | 1 | Shift direction: 0 = row 0 toward row ROWS-1, 1 = reverse |
| blank_n | input | 1 | Active-low blanking; clears the register and forces the row codes |
| ac | input | 1 | Frame AC polarity |
| cas1_in | input | 1 | Cascade pin 1 data in (used when dir_rev = 0) |
| cas2_in | input | 1 | Cascade pin 2 data in (used when dir_rev = 1) |
| cas1_out | output | 1 | Cascade pin 1 data out |
| cas2_out | output | 1 | Cascade pin 2 data out |
| cas1_oe | output | 1 | Output enable for cascade pin 1 |
| cas2_oe | output | 1 | Output enable for cascade pin 2 |
| row_lvl | output | 2*ROWS | Packed 2-bit level code per row |

## Verification
A scan falling edge and the start of blanking can land in the same system cycle. When they do, the blanking clear must win and the token presented at the input must never enter.

The bench provokes this by dropping `blank_n` on the same cycle that `scan_clk` falls, while `cas1_in` carries a 1. It first checks the forced row codes one time step after the drop. It then releases blanking and compares every row of the chained pair, plus the force-unselect instance, against a model that holds no token. A following scan step shows that shifting resumes from the empty state.

// File: rtl/lcdrow_pkg.sv
package lcdrow_pkg;

    // Drive level code, ordered from the top rail to the bottom rail
    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V1 = 2'b01,
        LVL_V4 = 2'b10,
        LVL_V5 = 2'b11
    } lvl_t;

    // Blanking behaviour chosen at build time
    typedef enum logic {
        BLANK_FORCE_TOP   = 1'b0,
        BLANK_FORCE_UNSEL = 1'b1
    } blank_mode_t;

    // One sampled set of the asynchronous scan inputs
    typedef struct packed {
        logic scan;
        logic d_fwd;
        logic d_rev;
    } scan_sample_t;

    // Non-select level for a given frame polarity
    function automatic lvl_t unsel_level(input logic ac);
        return ac ? LVL_V1 : LVL_V4;
    endfunction

    // Level for one row from its token bit, polarity and blanking
    function automatic lvl_t drive_level(input logic        sel,
                                         input logic        ac,
                                         input logic        blank_n,
                                         input blank_mode_t mode);
        lvl_t lv;
        if (!blank_n) begin
            lv = (mode == BLANK_FORCE_TOP) ? LVL_V0 : unsel_level(ac);
        end else if (sel) begin
            lv = ac ? LVL_V5 : LVL_V0;
        end else begin
            lv = unsel_level(ac);
        end
        return lv;
    endfunction

endpackage

// File: rtl/lcdrow_scan_sync.sv
module lcdrow_scan_sync
    import lcdrow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scan_clk,
    input  logic din_fwd,
    input  logic din_rev,
    output logic fall_evt,
    output logic din_fwd_s,
    output logic din_rev_s
);
    localparam int LAST = SYNC_STAGES - 1;

    scan_sample_t pipe [SYNC_STAGES];
    logic         scan_prev;

    // Clock and data travel through the same number of stages, so the
    // data seen with a detected edge is the data present when it fell.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                pipe[i] <= '0;
            end
            scan_prev <= 1'b0;
        end else begin
            pipe[0] <= '{scan: scan_clk, d_fwd: din_fwd, d_rev: din_rev};
            for (int i = 1; i < SYNC_STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
            scan_prev <= pipe[LAST].scan;
        end
    end

    assign fall_evt  = scan_prev & ~pipe[LAST].scan;
    assign din_fwd_s = pipe[LAST].d_fwd;
    assign din_rev_s = pipe[LAST].d_rev;

endmodule

// File: rtl/lcdrow_shift_reg.sv
module lcdrow_shift_reg #(
    parameter int ROWS = 100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            clear,
    input  logic            dir_rev,
    input  logic            din_fwd,
    input  logic            din_rev,
    output logic [ROWS-1:0] stages
);
    localparam int TOP = ROWS - 1;

    logic [ROWS-1:0] nxt;

    // Per-stage source: lower neighbour going forward, upper going back
    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_stage
            logic from_low;
            logic from_high;
            if (r == 0) begin : g_first
                assign from_low = din_fwd;
            end else begin : g_inner_low
                assign from_low = stages[r-1];
            end
            if (r == TOP) begin : g_last
                assign from_high = din_rev;
            end else begin : g_inner_high
                assign from_high = stages[r+1];
            end
            assign nxt[r] = dir_rev ? from_high : from_low;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stages <= '0;
        end else if (shift_en) begin
            stages <= nxt;
        end
    end

endmodule

// File: rtl/lcdrow_level_enc.sv
module lcdrow_level_enc
    import lcdrow_pkg::*;
#(
    parameter int          ROWS       = 100,
    parameter blank_mode_t BLANK_MODE = BLANK_FORCE_TOP
) (
    input  logic [ROWS-1:0]   sel,
    input  logic              ac,
    input  logic              blank_n,
    output logic [2*ROWS-1:0] lvl_bus
);
    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            lvl_t lv;
            assign lv = drive_level(sel[r], ac, blank_n, BLANK_MODE);
            assign lvl_bus[2*r +: 2] = lv;
        end
    endgenerate

endmodule

// File: rtl/lcdrow_scan.sv
module lcdrow_scan
    import lcdrow_pkg::*;
#(
    parameter int          ROWS        = 100,
    parameter int          SYNC_STAGES = 2,
    parameter blank_mode_t BLANK_MODE  = BLANK_FORCE_TOP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_clk,
    input  logic              dir_rev,
    input  logic              blank_n,
    input  logic              ac,
    input  logic              cas1_in,
    input  logic              cas2_in,
    output logic              cas1_out,
    output logic              cas2_out,
    output logic              cas1_oe,
    output logic              cas2_oe,
    output logic [2*ROWS-1:0] row_lvl
);
    localparam int TOP = ROWS - 1;

    logic            fall_evt;
    logic            din_fwd_s;
    logic            din_rev_s;
    logic            shift_en;
    logic [ROWS-1:0] scan_q;

    lcdrow_scan_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scan_clk  (scan_clk),
        .din_fwd   (cas1_in),
        .din_rev   (cas2_in),
        .fall_evt  (fall_evt),
        .din_fwd_s (din_fwd_s),
        .din_rev_s (din_rev_s)
    );

    // Blanking outranks a scan edge that arrives in the same cycle
    assign shift_en = fall_evt & blank_n;

    lcdrow_shift_reg #(
        .ROWS (ROWS)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .clear    (~blank_n),
        .dir_rev  (dir_rev),
        .din_fwd  (din_fwd_s),
        .din_rev  (din_rev_s),
        .stages   (scan_q)
    );

    lcdrow_level_enc #(
        .ROWS       (ROWS),
        .BLANK_MODE (BLANK_MODE)
    ) u_enc (
        .sel     (scan_q),
        .ac      (ac),
        .blank_n (blank_n),
        .lvl_bus (row_lvl)
    );

    // Pin roles swap with the direction
    assign cas1_oe  = dir_rev;
    assign cas2_oe  = ~dir_rev;
    assign cas1_out = dir_rev & scan_q[0];
    assign cas2_out = ~dir_rev & scan_q[TOP];

endmodule

// File: rtl/lcdrow_scan_chk.sv
module lcdrow_scan_chk
    import lcdrow_pkg::*;
#(
    parameter int          ROWS       = 100,
    parameter blank_mode_t BLANK_MODE = BLANK_FORCE_TOP
) (
    input logic              clk,
    input logic              rst,
    input logic              blank_n,
    input logic              ac,
    input logic              dir_rev,
    input logic              shift_en,
    input logic              din_fwd_s,
    input logic              din_rev_s,
    input logic [ROWS-1:0]   scan_q,
    input logic [2*ROWS-1:0] row_lvl
);
    p_fwd_shift_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(shift_en) && !$past(dir_rev) && !$past(rst))
        |-> (scan_q == {$past(scan_q[ROWS-2:0]), $past(din_fwd_s)}));

    p_rev_shift_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(shift_en) && $past(dir_rev) && !$past(rst))
        |-> (scan_q == {$past(din_rev_s), $past(scan_q[ROWS-1:1])}));

    p_row0_level_r5: assert property (@(posedge clk) disable iff (rst)
        (blank_n && scan_q[0]) |-> (row_lvl[1:0] == (ac ? 2'b11 : 2'b00)));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(blank_n) && !$past(rst)) |-> (scan_q == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(shift_en) && $past(blank_n) && !$past(rst)) |-> $stable(scan_q));

    generate
        if (BLANK_MODE == BLANK_FORCE_TOP) begin : g_top
            p_blank_top_r6: assert property (@(posedge clk) disable iff (rst)
                !blank_n |-> (row_lvl == '0));
        end else begin : g_unsel
            p_blank_unsel_r7: assert property (@(posedge clk) disable iff (rst)
                !blank_n |-> (row_lvl == {ROWS{(ac ? 2'b01 : 2'b10)}}));
        end
    endgenerate

endmodule

bind lcdrow_scan lcdrow_scan_chk #(
    .ROWS       (ROWS),
    .BLANK_MODE (BLANK_MODE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .blank_n   (blank_n),
    .ac        (ac),
    .dir_rev   (dir_rev),
    .shift_en  (shift_en),
    .din_fwd_s (din_fwd_s),
    .din_rev_s (din_rev_s),
    .scan_q    (scan_q),
    .row_lvl   (row_lvl)
);

// File: tb/lcdrow_scan_tb.sv
module lcdrow_scan_tb;
    import lcdrow_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 100;
    localparam int TOTAL = 2 * ROWS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_clk = 1'b0;
    logic dir_rev = 1'b0;
    logic blank_n = 1'b1;
    logic ac = 1'b0;
    logic d_in1 = 1'b0;
    logic d_in2 = 1'b0;

    logic a_c1o, a_c2o, a_c1e, a_c2e;
    logic b_c1o, b_c2o, b_c1e, b_c2e;
    logic i_c1o, i_c2o, i_c1e, i_c2e;
    logic [2*ROWS-1:0] a_lvl, b_lvl, i_lvl;
    logic link;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Shared pin between the two chained blocks, resolved by output enables
    assign link = a_c2e ? a_c2o : b_c1o;

    lcdrow_scan #(.ROWS(ROWS), .BLANK_MODE(BLANK_FORCE_TOP)) u_dut (
        .clk(clk), .rst(rst), .scan_clk(scan_clk), .dir_rev(dir_rev),
        .blank_n(blank_n), .ac(ac), .cas1_in(d_in1), .cas2_in(link),
        .cas1_out(a_c1o), .cas2_out(a_c2o), .cas1_oe(a_c1e), .cas2_oe(a_c2e),
        .row_lvl(a_lvl));

    lcdrow_scan #(.ROWS(ROWS), .BLANK_MODE(BLANK_FORCE_TOP)) u_dut_b (
        .clk(clk), .rst(rst), .scan_clk(scan_clk), .dir_rev(dir_rev),
        .blank_n(blank_n), .ac(ac), .cas1_in(link), .cas2_in(d_in2),
        .cas1_out(b_c1o), .cas2_out(b_c2o), .cas1_oe(b_c1e), .cas2_oe(b_c2e),
        .row_lvl(b_lvl));

    lcdrow_scan #(.ROWS(ROWS), .BLANK_MODE(BLANK_FORCE_UNSEL)) u_dut_inh (
        .clk(clk), .rst(rst), .scan_clk(scan_clk), .dir_rev(dir_rev),
        .blank_n(blank_n), .ac(ac), .cas1_in(d_in1), .cas2_in(link),
        .cas1_out(i_c1o), .cas2_out(i_c2o), .cas1_oe(i_c1e), .cas2_oe(i_c2e),
        .row_lvl(i_lvl));

    // Bench model of the 200-row chain
    bit model [TOTAL];

    typedef struct {
        logic [2*ROWS-1:0] exp_a;
        logic [2*ROWS-1:0] exp_b;
        logic [2*ROWS-1:0] exp_i;
        logic              exp_link;
        logic              exp_tail;
        logic              exp_idle;
        string             req;
    } item_t;

    item_t exp_q[$];

    function automatic logic [1:0] lv(bit sel, logic acv, logic bl, bit inh);
        if (!bl) return inh ? (acv ? 2'b01 : 2'b10) : 2'b00;
        if (sel) return acv ? 2'b11 : 2'b00;
        return acv ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [2*ROWS-1:0] exp_rows(int base, bit inh);
        logic [2*ROWS-1:0] v;
        for (int r = 0; r < ROWS; r++) v[2*r +: 2] = lv(model[base+r], ac, blank_n, inh);
        return v;
    endfunction

    task automatic check_vec(string req, logic [2*ROWS-1:0] act, logic [2*ROWS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic push_expect(string req);
        item_t it;
        it.exp_a    = exp_rows(0, 1'b0);
        it.exp_b    = exp_rows(ROWS, 1'b0);
        it.exp_i    = exp_rows(0, 1'b1);
        it.exp_link = dir_rev ? model[ROWS] : model[ROWS-1];
        it.exp_tail = dir_rev ? model[0] : model[TOTAL-1];
        it.req      = req;
        exp_q.push_back(it);
    endtask

    // Driver: one scan period, then the model advances and an item is queued
    task automatic scan_step(bit d1, bit d2, logic acv, string req);
        @(negedge clk);
        d_in1 = d1; d_in2 = d2; ac = acv; scan_clk = 1'b1;
        repeat (4) @(negedge clk);
        scan_clk = 1'b0;
        repeat (5) @(negedge clk);
        if (!dir_rev) begin
            for (int g = TOTAL - 1; g > 0; g--) model[g] = model[g-1];
            model[0] = d1;
        end else begin
            for (int g = 0; g < TOTAL - 1; g++) model[g] = model[g+1];
            model[TOTAL-1] = d2;
        end
        push_expect(req);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops queued items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check_vec({it.req, " rows A"}, a_lvl, it.exp_a);
                check_vec({it.req, " rows B"}, b_lvl, it.exp_b);
                check_vec({it.req, " rows unsel variant"}, i_lvl, it.exp_i);
                check_bit({it.req, " link pin R4"}, link, it.exp_link);
                check_bit({it.req, " chain tail R4"}, dir_rev ? a_c1o : b_c2o, it.exp_tail);
                check_bit("R4 idle output pin", dir_rev ? a_c2o : a_c1o, 1'b0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int g = 0; g < TOTAL; g++) model[g] = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: empty register, ac low -> every code 10
        check_vec("R1 reset rows", a_lvl, {ROWS{2'b10}});
        check_vec("R1 reset rows inh", i_lvl, {ROWS{2'b10}});
        check_bit("R2 cas1_oe forward", a_c1e, 1'b0);
        check_bit("R2 cas2_oe forward", a_c2e, 1'b1);

        // R2 R4 R5 R9: single token forward through 200 rows, ac varies
        scan_step(1'b1, 1'b0, 1'b1, "R2 inject");
        for (int s = 1; s < 205; s++) begin
            scan_step(1'b0, 1'b0, logic'((s % 7) < 3), "R2 R5 forward");
        end

        // Several tokens, R5 with both polarities
        scan_step(1'b1, 1'b0, 1'b0, "R5 pattern");
        scan_step(1'b1, 1'b0, 1'b1, "R5 pattern");
        scan_step(1'b0, 1'b0, 1'b0, "R5 pattern");
        scan_step(1'b1, 1'b0, 1'b1, "R5 pattern");

        // R9: no edge, ac flips; register holds, only codes follow ac
        @(negedge clk);
        ac = 1'b0;
        repeat (6) @(negedge clk);
        push_expect("R9 hold");
        repeat (2) @(negedge clk);

        // R6 R7 R8: blanking falls together with a scan edge carrying a 1
        @(negedge clk);
        d_in1 = 1'b1; ac = 1'b1; scan_clk = 1'b1;
        repeat (4) @(negedge clk);
        scan_clk = 1'b0;
        blank_n = 1'b0;
        #1;
        check_vec("R6 immediate force top", a_lvl, '0);
        check_vec("R6 immediate force top B", b_lvl, '0);
        check_vec("R7 immediate force unsel ac=1", i_lvl, {ROWS{2'b01}});
        repeat (3) @(negedge clk);
        ac = 1'b0;
        #1;
        check_vec("R6 force top ac=0", a_lvl, '0);
        check_vec("R7 force unsel ac=0", i_lvl, {ROWS{2'b10}});
        repeat (3) @(negedge clk);
        blank_n = 1'b1;
        for (int g = 0; g < TOTAL; g++) model[g] = 1'b0;
        repeat (2) @(negedge clk);
        push_expect("R8 cleared, coinciding edge ignored");
        repeat (2) @(negedge clk);
        scan_step(1'b1, 1'b0, 1'b1, "R8 resume");
        scan_step(1'b0, 1'b0, 1'b0, "R8 resume");

        // R3 R4: reverse direction, token enters at row 199
        @(negedge clk);
        dir_rev = 1'b1;
        #1;
        check_bit("R3 cas1_oe reverse", a_c1e, 1'b1);
        check_bit("R3 cas2_oe reverse", a_c2e, 1'b0);
        scan_step(1'b0, 1'b1, 1'b0, "R3 inject");
        for (int s = 1; s < 205; s++) begin
            scan_step(1'b0, 1'b0, logic'((s % 5) < 2), "R3 R5 reverse");
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule